// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the bus write port of a flash memory and turns a stream of write cycles into commands. Each write strobe brings an address and a data word. The low byte of the data carries the command code. A two-write unlock prefix guards the multi-cycle commands. After the prefix come a setup write, and then either a confirm write or one or two address/data writes. The block reports the mode that decides what a read returns: array contents, query data, identification data or status. It also holds a configuration value. When a program operation starts, it sends a one-cycle start pulse that carries the address and data it latched.

A small controller model stands in for the program/erase engine. It reports busy for a fixed number of cycles and flags an error when a program write would need to turn a 0 bit into a 1. In unlock-free (fast) mode, single and double program commands can be issued without the prefix. Any write that does not fit a valid sequence drops the block back to array read.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, rd_mode is 0 (array), cfg_reg is 0, pd_mode is 0, bypass_on is 0, and busy and prog_start are 0.
- R2: rd_mode encodes 0 = array, 1 = query, 2 = identification, 3 = status. A write whose data low byte is 0xF0, at any address, returns rd_mode to 0. This holds with or without the two unlock writes in front of it.
- R3: A write of 0x98 to an address whose low byte is 0x55 sets rd_mode to 1. In modes 1 and 2, every write whose data low byte is not 0xF0 is ignored, including unlock writes.
- R4: The unlock writes are 0xAA at address 0x555 and then 0x55 at address 0x2AA, compared on address bits [10:0]. These followed by 0x90 at 0x555 set rd_mode to 2. In mode 2, asel_data depends on rd_sel: 0 gives MFR_ID, 1 gives DEV_ID, 2 gives cfg_reg, 3 gives 0. In any other mode asel_data is 0.
- R5: Unlock, then 0x60 at 0x555, then 0x03 at any address loads cfg_reg from address bits [15:0]; pd_mode shows address bit 10. Any other confirm byte leaves cfg_reg unchanged and sets rd_mode to 0.
- R6: Unlock, then 0xA0 at 0x555, then one write gives a single-cycle prog_start in the cycle after that write. The pulse carries prog_dual=0 and the written address and data, and rd_mode becomes 3.
- R7: Unlock, then 0x50 at 0x555, then two writes whose addresses differ at most in bit 0, gives one prog_start with prog_dual=1. The pulse carries the first address, the first word on prog_data0 and the second word on prog_data1. If the addresses differ in any other bit, no pulse is issued and rd_mode becomes 0.
- R8: A write that breaks a sequence (a wrong second unlock, or an unknown code after the unlock) sets rd_mode to 0 and restarts decoding.
- R9: Unlock followed by 0x20 at 0x555 sets bypass_on. In this mode 0xA0 or 0x50 at any address opens a program command without an unlock, and 0xF0 returns rd_mode to 0 with bypass kept. 0x90 followed by 0x00 clears bypass_on. After that, a lone 0xA0 is invalid.
- R10: busy is high for exactly BUSY_CYCLES cycles, starting the cycle after prog_start. Writes sampled while busy or prog_start is high are ignored.
- R11: err is set at a start if any data bit is 1 where the matching old word bit is 0. For a double program this applies to either word. Otherwise err is 0. err changes only after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits [7:0] are the command code |
| rd_sel | input | 2 | Read address bits [1:0] that select identification data |
| old_word0 | input | DATA_W | Current array content at the first program address |
| old_word1 | input | DATA_W | Current array content at the second (double) address |
| rd_mode | output | 2 | Read mode: 0 array, 1 query, 2 identification, 3 status |
| asel_data | output | DATA_W | Identification data for the current rd_sel |
| cfg_reg | output | 16 | Configuration value |
| pd_mode | output | 1 | Configuration bit 10: 0 reset function, 1 power-down |
| bypass_on | output | 1 | Unlock-free command mode active |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_dual | output | 1 | Start is for two words |
| prog_addr | output | ADDR_W | Program address (first word) |
| prog_data0 | output | DATA_W | First program word |
| prog_data1 | output | DATA_W | Second program word (double only) |
| busy | output | 1 | Controller model busy |
| err | output | 1 | Last program tried to set a 0 bit to 1 |

## Verification
The assertions assume that wr_en is a single-cycle strobe sampled on the rising edge. They also assume that old_word0 and old_word1 are steady around the cycle of a start pulse, since the error flag samples them there. The bench drives every write as a one-cycle pulse at the falling edge and changes the old-word inputs only while the block is idle. It deliberately sends writes during busy cycles to exercise the ignore rule, and it expects each start pulse in the cycle after the data write.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command interpreter.
// Assumes the command code sits in the low byte of the write data.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_CFI    = 2'd1,
        MODE_ASEL   = 2'd2,
        MODE_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UL1, SQ_UL2, SQ_CFG, SQ_PGM, SQ_DW1, SQ_DW2, SQ_BYX
    } seq_e;

    localparam logic [10:0] UNLOCK_A1 = 11'h555;
    localparam logic [10:0] UNLOCK_A2 = 11'h2AA;
    localparam logic [7:0]  UNLOCK_D1 = 8'hAA;
    localparam logic [7:0]  UNLOCK_D2 = 8'h55;
    localparam logic [7:0]  CFI_ADDR  = 8'h55;
    localparam logic [7:0]  CMD_RESET = 8'hF0;
    localparam logic [7:0]  CMD_CFI   = 8'h98;
    localparam logic [7:0]  CMD_ASEL  = 8'h90;
    localparam logic [7:0]  CMD_CFG   = 8'h60;
    localparam logic [7:0]  CMD_CFGOK = 8'h03;
    localparam logic [7:0]  CMD_PGM   = 8'hA0;
    localparam logic [7:0]  CMD_DWP   = 8'h50;
    localparam logic [7:0]  CMD_BYP   = 8'h20;
    localparam logic [7:0]  CMD_BYX   = 8'h00;

endpackage

// File: rtl/flash_cmd_decode.sv
// Command sequence decoder: tracks the unlock prefix, setup and data
// cycles, the read mode, the configuration value and the fast mode.
// Assumes wr_en is a single-cycle strobe; writes are dropped while the
// controller is busy or while a start pulse is out.
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy_i,
    output rd_mode_e          mode_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              bypass_o,
    output logic              start_o,
    output logic              dual_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data0_o,
    output logic [DATA_W-1:0] data1_o
);

    seq_e        seq_q;
    logic [7:0]  cmd;
    logic        at_ul1, at_ul2, at_cfi, accept, pair_ok;

    // Decode helpers for the current write.
    always_comb begin
        cmd     = wr_data[7:0];
        at_ul1  = (wr_addr[10:0] == UNLOCK_A1);
        at_ul2  = (wr_addr[10:0] == UNLOCK_A2);
        at_cfi  = (wr_addr[7:0] == CFI_ADDR);
        accept  = wr_en && !busy_i && !start_o;
        pair_ok = ((wr_addr ^ addr_o) >> 1) == '0;
    end

    // Sequence state, mode, configuration and start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= SQ_IDLE;
            mode_o   <= MODE_ARRAY;
            cfg_o    <= '0;
            bypass_o <= 1'b0;
            start_o  <= 1'b0;
            dual_o   <= 1'b0;
            addr_o   <= '0;
            data0_o  <= '0;
            data1_o  <= '0;
        end else begin
            start_o <= 1'b0;
            if (accept) begin
                if (mode_o == MODE_CFI || mode_o == MODE_ASEL) begin
                    seq_q <= SQ_IDLE;
                    if (cmd == CMD_RESET) mode_o <= MODE_ARRAY;
                end else begin
                    case (seq_q)
                        SQ_IDLE: begin
                            if (cmd == CMD_RESET) begin
                                mode_o <= MODE_ARRAY;
                            end else if (bypass_o) begin
                                if (cmd == CMD_PGM)       seq_q <= SQ_PGM;
                                else if (cmd == CMD_DWP)  seq_q <= SQ_DW1;
                                else if (cmd == CMD_ASEL) seq_q <= SQ_BYX;
                                else                      mode_o <= MODE_ARRAY;
                            end else if (at_ul1 && cmd == UNLOCK_D1) begin
                                seq_q <= SQ_UL1;
                            end else if (at_cfi && cmd == CMD_CFI) begin
                                mode_o <= MODE_CFI;
                            end else begin
                                mode_o <= MODE_ARRAY;
                            end
                        end
                        SQ_UL1: begin
                            if (at_ul2 && cmd == UNLOCK_D2) begin
                                seq_q <= SQ_UL2;
                            end else begin
                                seq_q  <= SQ_IDLE;
                                mode_o <= MODE_ARRAY;
                            end
                        end
                        SQ_UL2: begin
                            seq_q  <= SQ_IDLE;
                            mode_o <= MODE_ARRAY;
                            if (at_ul1) begin
                                case (cmd)
                                    CMD_ASEL: mode_o   <= MODE_ASEL;
                                    CMD_PGM:  begin seq_q <= SQ_PGM; mode_o <= mode_o; end
                                    CMD_DWP:  begin seq_q <= SQ_DW1; mode_o <= mode_o; end
                                    CMD_CFG:  begin seq_q <= SQ_CFG; mode_o <= mode_o; end
                                    CMD_BYP:  bypass_o <= 1'b1;
                                    default:  ;
                                endcase
                            end
                        end
                        SQ_CFG: begin
                            seq_q  <= SQ_IDLE;
                            mode_o <= MODE_ARRAY;
                            if (cmd == CMD_CFGOK) cfg_o <= wr_addr[CFG_W-1:0];
                        end
                        SQ_PGM: begin
                            seq_q   <= SQ_IDLE;
                            mode_o  <= MODE_STATUS;
                            start_o <= 1'b1;
                            dual_o  <= 1'b0;
                            addr_o  <= wr_addr;
                            data0_o <= wr_data;
                        end
                        SQ_DW1: begin
                            seq_q   <= SQ_DW2;
                            addr_o  <= wr_addr;
                            data0_o <= wr_data;
                        end
                        SQ_DW2: begin
                            seq_q <= SQ_IDLE;
                            if (pair_ok) begin
                                mode_o  <= MODE_STATUS;
                                start_o <= 1'b1;
                                dual_o  <= 1'b1;
                                data1_o <= wr_data;
                            end else begin
                                mode_o  <= MODE_ARRAY;
                            end
                        end
                        SQ_BYX: begin
                            seq_q  <= SQ_IDLE;
                            mode_o <= MODE_ARRAY;
                            if (cmd == CMD_BYX) bypass_o <= 1'b0;
                        end
                        default: seq_q <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/flash_pec_stub.sv
// Program controller model: counts a fixed busy window after each start
// and flags an attempt to raise a cleared bit. Assumes the old-word
// inputs are valid in the cycle of the start pulse.
module flash_pec_stub #(
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dual_i,
    input  logic [DATA_W-1:0] data0_i,
    input  logic [DATA_W-1:0] data1_i,
    input  logic [DATA_W-1:0] old0_i,
    input  logic [DATA_W-1:0] old1_i,
    output logic              busy_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             raise0, raise1;

    // Bits the program would have to set from 0 to 1.
    always_comb begin
        raise0 = |(data0_i & ~old0_i);
        raise1 = dual_i && |(data1_i & ~old1_i);
        busy_o = (cnt_q != '0);
    end

    // Busy window counter and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_o <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
            err_o <= raise0 || raise1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/flash_asel_mux.sv
// Identification read selector: picks a code by the two low read
// address bits while identification mode is active, zero otherwise.
module flash_asel_mux #(
    parameter int          DATA_W = 16,
    parameter int          CFG_W  = 16,
    parameter logic [15:0] MFR_ID = 16'h0020,
    parameter logic [15:0] DEV_ID = 16'h00A0
) (
    input  logic              asel_i,
    input  logic [1:0]        sel_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [DATA_W-1:0] data_o
);

    // Select the identification word.
    always_comb begin
        data_o = '0;
        if (asel_i) begin
            case (sel_i)
                2'd0:    data_o = DATA_W'(MFR_ID);
                2'd1:    data_o = DATA_W'(DEV_ID);
                2'd2:    data_o = DATA_W'(cfg_i);
                default: data_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Flash command sequence interpreter top: decoder, controller model and
// identification mux. Assumes ADDR_W >= 16 and DATA_W >= 8.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          DATA_W      = 16,
    parameter int          BUSY_CYCLES = 6,
    parameter logic [15:0] MFR_ID      = 16'h0020,
    parameter logic [15:0] DEV_ID      = 16'h00A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [DATA_W-1:0] old_word0,
    input  logic [DATA_W-1:0] old_word1,
    output logic [1:0]        rd_mode,
    output logic [DATA_W-1:0] asel_data,
    output logic [15:0]       cfg_reg,
    output logic              pd_mode,
    output logic              bypass_on,
    output logic              prog_start,
    output logic              prog_dual,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data0,
    output logic [DATA_W-1:0] prog_data1,
    output logic              busy,
    output logic              err
);

    localparam int CFG_W  = 16;
    localparam int PD_BIT = 10;

    rd_mode_e mode;

    flash_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy_i(busy), .mode_o(mode), .cfg_o(cfg_reg),
        .bypass_o(bypass_on), .start_o(prog_start), .dual_o(prog_dual),
        .addr_o(prog_addr), .data0_o(prog_data0), .data1_o(prog_data1)
    );

    flash_pec_stub #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_pec (
        .clk(clk), .rst_n(rst_n), .start_i(prog_start), .dual_i(prog_dual),
        .data0_i(prog_data0), .data1_i(prog_data1), .old0_i(old_word0),
        .old1_i(old_word1), .busy_o(busy), .err_o(err)
    );

    flash_asel_mux #(.DATA_W(DATA_W), .CFG_W(CFG_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .asel_i(mode == MODE_ASEL), .sel_i(rd_sel), .cfg_i(cfg_reg), .data_o(asel_data)
    );

    // Port views of the mode and configuration bit.
    always_comb begin
        rd_mode = mode;
        pd_mode = cfg_reg[PD_BIT];
    end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Property checker for the command interpreter, attached by bind.
// Assumes wr_en is a single-cycle strobe sampled on the rising edge.
module flash_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  rd_mode,
    input logic [15:0] cfg_reg,
    input logic        prog_start,
    input logic        busy,
    input logic        err
);

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    assert_start_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> rd_mode == 2'd3);

    assert_busy_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);

    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (busy || prog_start)) |=> ($stable(rd_mode) && $stable(cfg_reg)));

    assert_cfg_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_reg));

    assert_err_only_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_start |=> $stable(err));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_mode(rd_mode),
    .cfg_reg(cfg_reg), .prog_start(prog_start), .busy(busy), .err(err)
);

// File: tb/flash_cmd_seq_tb.sv
// Scoreboard bench: the driver queues each expected start, a monitor
// pops and compares on every start pulse; direct checks cover modes.
module flash_cmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int BC = 6;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic          dual;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0, old_word0 = '1, old_word1 = '1;
    logic [1:0] rd_sel = 2'd0, rd_mode;
    logic [DW-1:0] asel_data, prog_data0, prog_data1;
    logic [15:0] cfg_reg;
    logic pd_mode, bypass_on, prog_start, prog_dual, busy, err;
    logic [AW-1:0] prog_addr;

    int total = 0, bad = 0;
    bit done = 0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .old_word0(old_word0), .old_word1(old_word1),
        .rd_mode(rd_mode), .asel_data(asel_data), .cfg_reg(cfg_reg), .pd_mode(pd_mode),
        .bypass_on(bypass_on), .prog_start(prog_start), .prog_dual(prog_dual),
        .prog_addr(prog_addr), .prog_data0(prog_data0), .prog_data1(prog_data1),
        .busy(busy), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0055);
    endtask

    task automatic expect_start(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                                input logic [DW-1:0] d1, input logic dual);
        item_t it;
        it.a = a; it.d0 = d0; it.d1 = d1; it.dual = dual;
        q.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || prog_start) @(negedge clk);
    endtask

    // Monitor: compare each start pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && prog_start) begin
            if (q.size() == 0) begin
                chk("R6/R7 unexpected start", 32'(prog_addr), 32'hFFFFFFFF);
            end else begin
                item_t it;
                it = q.pop_front();
                chk("R6 start addr", 32'(prog_addr), 32'(it.a));
                chk("R6 start data0", 32'(prog_data0), 32'(it.d0));
                chk("R7 start dual", 32'(prog_dual), 32'(it.dual));
                if (it.dual) chk("R7 start data1", 32'(prog_data1), 32'(it.d1));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(rd_mode), 0);
        chk("R1 cfg", 32'(cfg_reg), 0);
        chk("R1 pd", 32'(pd_mode), 0);
        chk("R1 bypass", 32'(bypass_on), 0);
        chk("R1 busy/start", 32'({busy, prog_start}), 0);

        // R3 query mode and its lock
        wr(20'h00055, 16'h0098);
        chk("R3 cfi entry", 32'(rd_mode), 1);
        unlock();
        wr(20'h00555, 16'h0090);
        chk("R3 writes ignored in cfi", 32'(rd_mode), 1);
        wr(20'h12345, 16'h00F0);
        chk("R2 reset from cfi", 32'(rd_mode), 0);

        // R5 configuration load and bad confirm
        unlock(); wr(20'h00555, 16'h0060); wr(20'h10455, 16'h0003);
        chk("R5 cfg value", 32'(cfg_reg), 32'h0455);
        chk("R5 pd bit", 32'(pd_mode), 1);
        unlock(); wr(20'h00555, 16'h0060); wr(20'h01234, 16'h0004);
        chk("R5 bad confirm cfg kept", 32'(cfg_reg), 32'h0455);
        chk("R5 bad confirm mode", 32'(rd_mode), 0);

        // R4 identification mode
        rd_sel = 2'd0; #1;
        chk("R4 zero outside mode 2", 32'(asel_data), 0);
        unlock(); wr(20'h00555, 16'h0090);
        chk("R4 asel entry", 32'(rd_mode), 2);
        rd_sel = 2'd0; #1; chk("R4 sel0 mfr", 32'(asel_data), 32'h0020);
        rd_sel = 2'd1; #1; chk("R4 sel1 dev", 32'(asel_data), 32'h00A0);
        rd_sel = 2'd2; #1; chk("R4 sel2 cfg", 32'(asel_data), 32'h0455);
        rd_sel = 2'd3; #1; chk("R4 sel3 zero", 32'(asel_data), 0);
        wr(20'h00055, 16'h0098);
        chk("R3 cfi ignored in asel", 32'(rd_mode), 2);
        wr(20'h00000, 16'h00F0);
        chk("R2 reset from asel", 32'(rd_mode), 0);

        // R6 program, R10 ignore while busy, R11 no error
        old_word0 = 16'hFFFF;
        unlock(); wr(20'h00555, 16'h00A0);
        expect_start(20'h12345, 16'hBEEF, 16'h0, 1'b0);
        wr(20'h12345, 16'hBEEF);
        chk("R6 start pulse", 32'(prog_start), 1);
        chk("R6 status mode", 32'(rd_mode), 3);
        wr(20'h00000, 16'h00F0);
        chk("R10 write ignored while busy", 32'(rd_mode), 3);
        wait_idle();
        chk("R11 no error", 32'(err), 0);
        wr(20'h00555, 16'h00AA);
        chk("R2 unlock keeps status", 32'(rd_mode), 3);
        wr(20'h002AA, 16'h0055);
        wr(20'h00555, 16'h00F0);
        chk("R2 reset after unlock", 32'(rd_mode), 0);

        // R10 busy window length, R11 error raise
        old_word0 = 16'h00FF;
        unlock(); wr(20'h00555, 16'h00A0);
        expect_start(20'h00040, 16'h01FF, 16'h0, 1'b0);
        wr(20'h00040, 16'h01FF);
        n = 0;
        @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        chk("R10 busy length", 32'(n), BC);
        chk("R11 error raised", 32'(err), 1);
        unlock(); wr(20'h00555, 16'h00A0);
        expect_start(20'h00041, 16'h0011, 16'h0, 1'b0);
        wr(20'h00041, 16'h0011);
        wait_idle();
        chk("R11 error cleared", 32'(err), 0);

        // R8 broken sequences
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0056);
        chk("R8 wrong second unlock", 32'(rd_mode), 0);
        unlock(); wr(20'h00555, 16'h00A0);
        expect_start(20'h00042, 16'h0001, 16'h0, 1'b0);
        wr(20'h00042, 16'h0001);
        wait_idle();
        unlock(); wr(20'h00555, 16'h0077);
        chk("R8 unknown code", 32'(rd_mode), 0);

        // R7 double program, error on second word, abort
        old_word0 = 16'hFFFF; old_word1 = 16'hFFFF;
        unlock(); wr(20'h00555, 16'h0050);
        wr(20'h00200, 16'h1111);
        expect_start(20'h00200, 16'h1111, 16'h2222, 1'b1);
        wr(20'h00201, 16'h2222);
        chk("R7 dual start", 32'(prog_start), 1);
        wait_idle();
        chk("R11 dual no error", 32'(err), 0);
        old_word1 = 16'h0000;
        unlock(); wr(20'h00555, 16'h0050);
        wr(20'h00300, 16'h0000);
        expect_start(20'h00300, 16'h0000, 16'h0004, 1'b1);
        wr(20'h00301, 16'h0004);
        wait_idle();
        chk("R11 dual second word error", 32'(err), 1);
        unlock(); wr(20'h00555, 16'h0050);
        wr(20'h00200, 16'h1111);
        wr(20'h00203, 16'h2222);
        chk("R7 abort no start", 32'(prog_start), 0);
        chk("R7 abort mode", 32'(rd_mode), 0);

        // R9 unlock-free mode
        old_word1 = 16'hFFFF;
        unlock(); wr(20'h00555, 16'h0020);
        chk("R9 bypass entry", 32'(bypass_on), 1);
        wr(20'h03000, 16'h00A0);
        expect_start(20'h00010, 16'h0F0F, 16'h0, 1'b0);
        wr(20'h00010, 16'h0F0F);
        chk("R9 bypass program", 32'(prog_start), 1);
        wait_idle();
        wr(20'h07777, 16'h0050);
        wr(20'h00400, 16'h0101);
        expect_start(20'h00400, 16'h0101, 16'h0202, 1'b1);
        wr(20'h00401, 16'h0202);
        wait_idle();
        wr(20'h00000, 16'h00F0);
        chk("R9 reset keeps bypass", 32'({bypass_on, rd_mode}), 32'h4);
        wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000);
        chk("R9 bypass exit", 32'(bypass_on), 0);
        wr(20'h00000, 16'h00A0); wr(20'h00040, 16'h1234);
        chk("R9 lone program invalid", 32'({prog_start, rd_mode}), 0);
        repeat (BC + 2) @(negedge clk);
        chk("R6 scoreboard drained", 32'(q.size()), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule